// File: doc/BRIEF.md
# Vectored Interrupt Controller with Flag Shadowing

This block arbitrates eight interrupt sources for a small 8-bit processor core. Each source owns one bit in a pending-request register and one bit in an enable (mask) register. A global enable sits in bit 0 of a processor flags register that the controller holds. When some request is pending, its mask bit is set and the global enable is 1, the controller raises a registered interrupt line to the core. It also presents the entry address of the lowest-numbered eligible source.

When the core accepts the interrupt with an acknowledge pulse, the controller saves the flags into a shadow register and drops the global enable. A return strobe reloads the flags from the shadow. The shadow sits at its own bus address, so an interrupt routine can save it, re-enable interrupts to allow nesting, and restore it before returning. Two external pins are synchronised and watched for an edge whose direction software selects per pin. A matching edge raises the request bit of that pin's source.

Top module: `irq_vec_ctrl`

## Requirements
- R1: `irq_req` is 1 only when, in the previous cycle, some source had both its request bit and its mask bit at 1 and flags bit 0 was 1. Otherwise it is 0.
- R2: An `ack` pulse copies the whole flags register into the shadow register and clears flags bit 0 on the same clock edge.
- R3: A `reti` pulse with no `ack` reloads the flags register from the shadow register.
- R4: Register addresses are: request = 0, mask = 1, polarity = 2, flags = 3, shadow = 4. The shadow register reads back what was written to it, and a later `reti` loads that value into flags.
- R5: `vec_addr` is 4*(n+1), where n is the lowest-numbered source whose request and mask bits are both 1. Source 0 gives 0x04 and source 7 gives 0x20.
- R6: Bit n of `src_set` raises request bit n. Pin A (`ext_pin[0]`) feeds source 3 and pin B (`ext_pin[1]`) feeds source 6, so pin B vectors to 0x1C.
- R7: Polarity bit 0 (pin A) and bit 1 (pin B) select the edge: 0 selects a rising edge and 1 selects a falling edge. An edge of the other direction sets nothing.
- R8: A pin edge raises its request only while that source's mask bit (bit 3 for A, bit 6 for B) is 1.
- R9: Writing the request register clears each bit written as 0 and leaves each bit written as 1 unchanged. Clearing a mask bit leaves the pending request set but drops `irq_req`.
- R10: If flags is written in the same cycle as `ack`, the shadow saves the written value. A write that clears bit 0 therefore leaves bit 0 at 0 after `reti`.
- R11: Acknowledge does not clear the request bit. It stays 1 until software clears it.
- R12: After reset, all registers read 0 and `irq_req` and `vec_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, data valid the next cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| src_set | input | 8 | One-cycle request pulses, one bit per source |
| ext_pin | input | 2 | External pin levels: bit 0 is pin A, bit 1 is pin B |
| ack | input | 1 | Core accepts the interrupt |
| reti | input | 1 | Core returns from the interrupt routine |
| irq_req | output | 1 | Registered interrupt request to the core |
| vec_addr | output | 8 | Registered entry address of the winning source |

## Verification
On every cycle, the assertions check four things:
- the interrupt line is never raised without an eligible request and the global enable;
- acknowledge always leaves the enable cleared and the shadow holding the prior flags;
- return restores the shadow;
- request bits never fall except through a bus write.

Only the directed scenarios can show the following:
- the exact vector chosen among competing sources;
- edge polarity and enable gating on each pin;
- write-zero clearing;
- shadow save and restore across a nested-style sequence;
- the saved value when flags is written in the same cycle as acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int NUM_PINS  = 2;
  localparam int PIN_A_SRC = 3;
  localparam int PIN_B_SRC = 6;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REQ    = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_POL    = 3'd2,
    SEL_FLAGS  = 3'd3,
    SEL_SHADOW = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  input  logic en,
  output logic hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];
  assign hit = en & (fall_sel ? (prev_q & ~cur) : (cur & ~prev_q));

  // R7
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 8,
  parameter int VEC_W = 8
) (
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    any = |pend;
    vec = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) vec = VEC_W'((i + 1) * 4);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   src_set,
  input  logic [NUM_PINS-1:0] ext_pin,
  input  logic              ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [DATA_W-1:0] vec_addr
);
  localparam int PIN_SRC [NUM_PINS] = '{PIN_A_SRC, PIN_B_SRC};

  logic [NSRC-1:0]     req_q, mask_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [DATA_W-1:0]   flags_q, shadow_q, flags_eff;
  logic [NUM_PINS-1:0] pin_hit;
  logic [NSRC-1:0]     edge_set, pend;
  logic                pend_any;
  logic [DATA_W-1:0]   win_vec;
  logic                wr_req, wr_mask, wr_pol, wr_flags, wr_shadow;

  assign wr_req    = wr_en && (addr == SEL_REQ);
  assign wr_mask   = wr_en && (addr == SEL_MASK);
  assign wr_pol    = wr_en && (addr == SEL_POL);
  assign wr_flags  = wr_en && (addr == SEL_FLAGS);
  assign wr_shadow = wr_en && (addr == SEL_SHADOW);

  generate
    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      irqc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin[gp]),
        .fall_sel (pol_q[gp]),
        .en       (mask_q[PIN_SRC[gp]]),
        .hit      (pin_hit[gp])
      );
    end
  endgenerate

  always_comb begin
    edge_set = '0;
    for (int p = 0; p < NUM_PINS; p++) edge_set[PIN_SRC[p]] = pin_hit[p];
  end

  // Request register: write-zero clears, new events win over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else begin
      req_q <= (wr_req ? (req_q & wdata[NSRC-1:0]) : req_q) | src_set | edge_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata[NSRC-1:0];
      if (wr_pol)  pol_q  <= wdata[NUM_PINS-1:0];
    end
  end

  // Flags as seen by an acknowledge taken in the same cycle as a write
  assign flags_eff = wr_flags ? wdata : flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      shadow_q <= '0;
    end else if (ack) begin
      shadow_q <= flags_eff;
      flags_q  <= {flags_eff[DATA_W-1:1], 1'b0};
    end else begin
      if (reti)          flags_q  <= shadow_q;
      else if (wr_flags) flags_q  <= wdata;
      if (wr_shadow)     shadow_q <= wdata;
    end
  end

  assign pend = req_q & mask_q;

  irqc_prio #(.N(NSRC), .VEC_W(DATA_W)) prio_i (
    .pend (pend),
    .any  (pend_any),
    .vec  (win_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      vec_addr <= '0;
    end else begin
      irq_req  <= pend_any & flags_q[0];
      vec_addr <= win_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        SEL_REQ:    rdata <= DATA_W'(req_q);
        SEL_MASK:   rdata <= DATA_W'(mask_q);
        SEL_POL:    rdata <= DATA_W'(pol_q);
        SEL_FLAGS:  rdata <= flags_q;
        SEL_SHADOW: rdata <= shadow_q;
        default:    rdata <= '0;
      endcase
    end
  end

  // R1
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(flags_q[0] && ((req_q & mask_q) != '0)));

  // R2
  ack_save_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr_flags) |=> (shadow_q == $past(flags_q)) && !flags_q[0]);

  // R3
  reti_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack) |=> flags_q == $past(shadow_q));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> (req_q & $past(req_q)) == $past(req_q));

  // R5
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (vec_addr[1:0] == 2'b00) && (vec_addr != '0));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en, ack, reti;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, src_set, vec_addr;
  logic [1:0] ext_pin;
  logic       irq_req;
  int         n_chk = 0, n_err = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_set(src_set), .ext_pin(ext_pin),
    .ack(ack), .reti(reti), .irq_req(irq_req), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_src(input logic [7:0] s);
    src_set = s;
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 irq_req", {7'b0, irq_req}, 8'h00);
    chk("R12 vec_addr", vec_addr, 8'h00);
    rd(3'd0, rv); chk("R12 req", rv, 8'h00);
    rd(3'd1, rv); chk("R12 mask", rv, 8'h00);
    rd(3'd3, rv); chk("R12 flags", rv, 8'h00);
    rd(3'd4, rv); chk("R12 shadow", rv, 8'h00);
  endtask

  task automatic t_gating();
    pulse_src(8'h10);
    settle(2);
    chk("R1 no mask", {7'b0, irq_req}, 8'h00);
    wr(3'd1, 8'h12);
    settle(2);
    chk("R1 no gie", {7'b0, irq_req}, 8'h00);
    wr(3'd3, 8'h01);
    settle(1);
    chk("R1 all set", {7'b0, irq_req}, 8'h01);
    chk("R5 vec src4", vec_addr, 8'h14);
    pulse_src(8'h02);
    settle(1);
    chk("R5 lowest wins", vec_addr, 8'h08);
  endtask

  task automatic t_ack_reti();
    pulse_ack();
    settle(1);
    chk("R2 irq drops", {7'b0, irq_req}, 8'h00);
    rd(3'd3, rv); chk("R2 flags gie clear", rv, 8'h00);
    rd(3'd4, rv); chk("R2 shadow saved", rv, 8'h01);
    rd(3'd0, rv); chk("R11 req kept", rv, 8'h12);
    pulse_reti();
    rd(3'd3, rv); chk("R3 flags restored", rv, 8'h01);
    settle(1);
    chk("R3 irq again", {7'b0, irq_req}, 8'h01);
    wr(3'd4, 8'h5A);
    rd(3'd4, rv); chk("R4 shadow rw", rv, 8'h5A);
    pulse_reti();
    rd(3'd3, rv); chk("R4 reti uses shadow", rv, 8'h5A);
  endtask

  task automatic t_mask_clear();
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h00);
    settle(2);
    chk("R9 mask blocks", {7'b0, irq_req}, 8'h00);
    rd(3'd0, rv); chk("R9 pending kept", rv, 8'h12);
    wr(3'd0, 8'hFF);
    rd(3'd0, rv); chk("R9 write one keeps", rv, 8'h12);
    wr(3'd0, 8'hFD);
    rd(3'd0, rv); chk("R9 write zero clears", rv, 8'h10);
    wr(3'd0, 8'h00);
    rd(3'd0, rv); chk("R9 all cleared", rv, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_edges();
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h00);
    ext_pin[0] = 1'b1; settle(5);
    rd(3'd0, rv); chk("R7 rise pin A", rv, 8'h08);
    wr(3'd0, 8'h00);
    ext_pin[0] = 1'b0; settle(5);
    rd(3'd0, rv); chk("R7 fall ignored", rv, 8'h00);
    wr(3'd2, 8'h01);
    ext_pin[0] = 1'b1; settle(5);
    rd(3'd0, rv); chk("R7 rise ignored", rv, 8'h00);
    ext_pin[0] = 1'b0; settle(5);
    rd(3'd0, rv); chk("R7 fall pin A", rv, 8'h08);
    wr(3'd0, 8'h00);
    ext_pin[1] = 1'b1; settle(5);
    rd(3'd0, rv); chk("R8 pin B disabled", rv, 8'h00);
    wr(3'd1, 8'h40);
    ext_pin[1] = 1'b0; settle(5);
    ext_pin[1] = 1'b1; settle(5);
    rd(3'd0, rv); chk("R6 pin B src6", rv, 8'h40);
    wr(3'd3, 8'h01);
    settle(1);
    chk("R6 pin B vector", vec_addr, 8'h1C);
    chk("R6 pin B irq", {7'b0, irq_req}, 8'h01);
  endtask

  task automatic t_same_cycle();
    wr_en = 1'b1; addr = 3'd3; wdata = 8'h80; ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ack = 1'b0;
    rd(3'd4, rv); chk("R10 shadow takes write", rv, 8'h80);
    pulse_reti();
    rd(3'd3, rv); chk("R10 gie stays 0", rv, 8'h80);
    settle(1);
    chk("R10 no irq", {7'b0, irq_req}, 8'h00);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; ack = 0; reti = 0;
    addr = '0; wdata = '0; src_set = '0; ext_pin = '0;
    settle(3);
    rst = 1'b0;
    settle(1);
    t_reset();
    t_gating();
    t_ack_reti();
    t_mask_clear();
    t_edges();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule